// File: doc/BRIEF.md
# Idle-Timeout Sleep Controller

This block decides when a small bus-attached device may stop its internal oscillator and sleep. It watches the two serial bus lines (clock line and data line) and an internal busy flag. When both lines have stayed high and nothing inside has been busy for a programmed number of coarse time steps, it raises `sleep_en`. The surrounding logic uses that output to withdraw the oscillator request. One step is `2**PRESC_W` clock cycles, which at an 8 MHz clock with the default `PRESC_W = 15` is 4.096 ms. The 13-bit step register resets to 8057 steps, about 33 seconds.

The clock is gone while the device sleeps, so the wake path cannot need it. A low level on either bus line clears `sleep_en` through an asynchronous clear as soon as it appears. When the oscillator runs again, a two-flop synchronizer carries the same wake condition into the state machine. The state machine then passes through a one-cycle re-arm state and starts a fresh idle count. For a fixed initialization period after reset, host writes to the step register are discarded. After that period the host may rewrite it at any time.

The state machine has four states:
- `ST_INIT`: initialization window. Writes are discarded and nothing is counted.
- `ST_ACTIVE`: idle counting.
- `ST_SLEEP`: `sleep_en` has been raised.
- `ST_WAKE`: one cycle that holds the counters cleared after a wake.

Its transitions are:
- INIT→ACTIVE when the init period expires.
- ACTIVE→SLEEP on the edge where the step count reaches the target.
- SLEEP→WAKE when the synchronized wake condition is seen.
- WAKE→ACTIVE unconditionally.

Top module: `slp_idle_ctrl`

## Requirements
- R1: While in ACTIVE with `scl_in`, `sda_in` high and `busy` low on every edge, `sleep_en` rises on exactly the `T*2**PRESC_W`-th such consecutive clock edge, where T is the effective step count. It rises only if the lines were high and `busy` low at that edge.
- R2: A low level on either bus line, or `busy` high, at any clock edge clears the cycle prescaler and the step counter. A full timeout is then needed again.
- R3: After reset, `sleep_en` is 0 and the 13-bit step register `cfg_timeout` holds `RESET_STEPS` (default 8057).
- R4: A write (`cfg_we` high at a clock edge) is discarded during the first `INIT_CYCLES` edges after reset. Afterwards it loads `cfg_wdata` into `cfg_timeout` on that edge.
- R5: A stored step value of 0 behaves as 1 step. The register still reads back 0.
- R6: `sleep_en` falls as soon as either bus line is low, with no clock edge needed, and it is never high while a line is low at a clock edge.
- R7: After a wake the block returns to counting. Once the lines are high again, a full new timeout is needed before `sleep_en` rises again.
- R8: If the register is lowered below the number of steps already counted, `sleep_en` rises at the next step boundary.
- R9: `sleep_en` never rises during the initialization period. It is high only while the state machine is in SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Active-low reset from the power-on detector |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| busy | input | 1 | High while any internal function is active |
| cfg_we | input | 1 | Step register write strobe |
| cfg_wdata | input | STEP_W | Step count to load |
| cfg_timeout | output | STEP_W | Current step register contents |
| sleep_en | output | 1 | High requests oscillator stop |

## Verification
The bench pins the exact edge where `sleep_en` rises, one edge early and on the edge, for the reset default, a programmed value and the zero value. An off-by-one in the prescaler or the step compare, or a zero value that wraps to the maximum, would move or lose that edge. Single-cycle disturbances (one `busy` pulse, one data-line dip) are placed late in a count. A design that failed to clear the prescaler or the counter would then sleep too early. Writes issued inside the init window, a timeout lowered mid-count, and a line pulled low with no clock edge between the drive and the sample each catch a different defect. They show a register that accepts writes too early, an equality compare that never fires once passed, and a wake that waits for a clock.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_SLEEP  = 2'd2,
        ST_WAKE   = 2'd3
    } slp_state_e;

endpackage

// File: rtl/slp_prescaler.sv
// Free-running cycle divider; emits one tick each 2**WIDTH enabled cycles.
module slp_prescaler #(
    parameter int WIDTH = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = !clr && (&cnt_q);

endmodule

// File: rtl/slp_step_counter.sv
// Counts prescaler ticks and flags the tick that completes the timeout.
module slp_step_counter #(
    parameter int WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [WIDTH-1:0] target,
    output logic             reach
);

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] last_step;

    assign last_step = target - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick && !(&cnt_q)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Greater-or-equal so a target lowered mid-count still fires.
    assign reach = tick && (cnt_q >= last_step);

endmodule

// File: rtl/slp_sync.sv
// Multi-stage resynchronizer for a level coming from outside the clock.
module slp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/slp_cfg_reg.sv
// Step register with reset default, write gate, and zero-as-one mapping.
module slp_cfg_reg #(
    parameter int WIDTH       = 13,
    parameter int RESET_STEPS = 8057
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             allow,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] target
);

    localparam logic [WIDTH-1:0] DEFAULT_VAL = WIDTH'(RESET_STEPS);

    logic [WIDTH-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= DEFAULT_VAL;
        end else if (we && allow) begin
            val_q <= wdata;
        end
    end

    assign value  = val_q;
    assign target = (val_q == '0) ? WIDTH'(1) : val_q;

endmodule

// File: rtl/slp_idle_ctrl.sv
module slp_idle_ctrl
    import slp_pkg::*;
#(
    parameter int PRESC_W     = 15,
    parameter int STEP_W      = 13,
    parameter int RESET_STEPS = 8057,
    parameter int INIT_CYCLES = 112000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              busy,
    input  logic              cfg_we,
    input  logic [STEP_W-1:0] cfg_wdata,
    output logic [STEP_W-1:0] cfg_timeout,
    output logic              sleep_en
);

    localparam int INIT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYCLES - 1);

    slp_state_e        state_q, state_d;
    logic [INIT_W-1:0] init_cnt_q;
    logic              init_done;
    logic              bus_idle;
    logic              wake_raw;
    logic              wake_sync;
    logic              cnt_clr;
    logic              step_tick;
    logic              step_reach;
    logic              enter_sleep;
    logic [STEP_W-1:0] step_target;
    logic              sleep_q;

    assign bus_idle    = scl_in && sda_in && !busy;
    assign wake_raw    = !scl_in || !sda_in;
    assign init_done   = (init_cnt_q == INIT_LAST);
    assign cnt_clr     = !(state_q == ST_ACTIVE && bus_idle);
    assign enter_sleep = (state_q == ST_ACTIVE) && step_reach;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_cnt_q <= '0;
        end else if (state_q == ST_INIT && !init_done) begin
            init_cnt_q <= init_cnt_q + 1'b1;
        end
    end

    slp_cfg_reg #(
        .WIDTH       (STEP_W),
        .RESET_STEPS (RESET_STEPS)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .allow  (state_q != ST_INIT),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .value  (cfg_timeout),
        .target (step_target)
    );

    slp_prescaler #(
        .WIDTH (PRESC_W)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (step_tick)
    );

    slp_step_counter #(
        .WIDTH (STEP_W)
    ) u_steps (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .tick   (step_tick),
        .target (step_target),
        .reach  (step_reach)
    );

    slp_sync #(
        .STAGES (SYNC_STAGES)
    ) u_wsync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wake_raw),
        .q     (wake_sync)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:   if (init_done)   state_d = ST_ACTIVE;
            ST_ACTIVE: if (enter_sleep) state_d = ST_SLEEP;
            ST_SLEEP:  if (wake_sync)   state_d = ST_WAKE;
            ST_WAKE:                    state_d = ST_ACTIVE;
            default:                    state_d = ST_INIT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // Output register: set on a clock edge, cleared by the bus lines with no clock.
    always_ff @(posedge clk or negedge rst_n or posedge wake_raw) begin
        if (!rst_n) begin
            sleep_q <= 1'b0;
        end else if (wake_raw) begin
            sleep_q <= 1'b0;
        end else if (enter_sleep) begin
            sleep_q <= 1'b1;
        end
    end

    assign sleep_en = sleep_q;

endmodule

// File: rtl/slp_idle_chk.sv
module slp_idle_chk
    import slp_pkg::*;
#(
    parameter int STEP_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              busy,
    input  logic              cfg_we,
    input  logic              sleep_en,
    input  logic [STEP_W-1:0] cfg_timeout,
    input  slp_state_e        state
);

    AST_WAKE_LOW_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_in || !sda_in) |-> !sleep_en); // R6

    AST_RISE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_en) |-> $past(scl_in && sda_in && !busy)); // R1

    AST_CFG_FROZEN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INIT) |=> $stable(cfg_timeout)); // R4

    AST_CFG_HOLD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_timeout)); // R4

    AST_SLEEP_ONLY_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_en |-> (state == ST_SLEEP)); // R9

    AST_NO_RISE_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INIT) |=> !sleep_en); // R9

endmodule

bind slp_idle_ctrl slp_idle_chk #(
    .STEP_W (STEP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_in      (scl_in),
    .sda_in      (sda_in),
    .busy        (busy),
    .cfg_we      (cfg_we),
    .sleep_en    (sleep_en),
    .cfg_timeout (cfg_timeout),
    .state       (state_q)
);

// File: tb/slp_idle_ctrl_tb.sv
module slp_idle_ctrl_tb;

    localparam int PRESC_W     = 3;
    localparam int STEP_W      = 13;
    localparam int RESET_STEPS = 20;
    localparam int INIT_CYCLES = 16;
    localparam int STEP_CYC    = 1 << PRESC_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl_in = 1'b1;
    logic              sda_in = 1'b1;
    logic              busy = 1'b0;
    logic              cfg_we = 1'b0;
    logic [STEP_W-1:0] cfg_wdata = '0;
    logic [STEP_W-1:0] cfg_timeout;
    logic              sleep_en;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    slp_idle_ctrl #(
        .PRESC_W     (PRESC_W),
        .STEP_W      (STEP_W),
        .RESET_STEPS (RESET_STEPS),
        .INIT_CYCLES (INIT_CYCLES)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .busy        (busy),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_timeout (cfg_timeout),
        .sleep_en    (sleep_en)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1; busy = 1'b0; cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // From a negedge, sleep_en must be low after n-1 edges and high after n.
    task automatic expect_sleep_at(input int n, input string req);
        repeat (n - 1) @(negedge clk);
        chk(req, sleep_en, 0);
        @(negedge clk);
        chk(req, sleep_en, 1);
    endtask

    task automatic restart_idle();
        scl_in = 1'b0;
        @(negedge clk);
        scl_in = 1'b1;
    endtask

    task automatic write_cfg(input int v);
        cfg_wdata = STEP_W'(v);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wake_up();
        scl_in = 1'b0;
        repeat (6) @(negedge clk);
        scl_in = 1'b1;
    endtask

    task automatic t_default();
        do_reset();
        chk("R3 sleep_en after reset", sleep_en, 0);
        chk("R3 default timeout", cfg_timeout, RESET_STEPS);
        // R9: init period plus full default timeout; R1 exact edge
        expect_sleep_at(INIT_CYCLES + RESET_STEPS * STEP_CYC, "R1 R9 default timeout");
    endtask

    task automatic t_async_wake();
        sda_in = 1'b0;
        #1;
        chk("R6 sleep_en falls without clock", sleep_en, 0);
        repeat (5) @(negedge clk);
        chk("R6 stays low while line low", sleep_en, 0);
        sda_in = 1'b1;
        expect_sleep_at(RESET_STEPS * STEP_CYC, "R7 full timeout after wake");
    endtask

    task automatic t_init_write();
        do_reset();
        repeat (2) @(negedge clk);
        write_cfg(7);
        chk("R4 write ignored in init", cfg_timeout, RESET_STEPS);
        repeat (20) @(negedge clk);
        write_cfg(7);
        chk("R4 write accepted after init", cfg_timeout, 7);
    endtask

    task automatic t_programmed();
        restart_idle();
        expect_sleep_at(7 * STEP_CYC, "R1 programmed 7 steps");
        wake_up();
    endtask

    task automatic t_restart();
        restart_idle();
        repeat (50) @(negedge clk);
        chk("R2 not asleep before busy", sleep_en, 0);
        busy = 1'b1;
        @(negedge clk);
        busy = 1'b0;
        expect_sleep_at(7 * STEP_CYC, "R2 busy pulse restarts count");
        wake_up();
        restart_idle();
        repeat (40) @(negedge clk);
        sda_in = 1'b0;
        @(negedge clk);
        sda_in = 1'b1;
        expect_sleep_at(7 * STEP_CYC, "R2 data dip restarts count");
        wake_up();
    endtask

    task automatic t_zero();
        write_cfg(0);
        chk("R5 zero reads back", cfg_timeout, 0);
        restart_idle();
        expect_sleep_at(STEP_CYC, "R5 zero acts as one step");
        wake_up();
    endtask

    task automatic t_lower();
        write_cfg(10);
        restart_idle();
        repeat (5 * STEP_CYC) @(negedge clk);
        chk("R8 not asleep mid count", sleep_en, 0);
        write_cfg(2);
        // one edge used by the write; next step boundary at 6*STEP_CYC
        expect_sleep_at(STEP_CYC - 1, "R8 lowered target fires next step");
        wake_up();
    endtask

    initial begin
        t_default();
        t_async_wake();
        t_init_write();
        t_programmed();
        t_restart();
        t_zero();
        t_lower();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule